// File: doc/BRIEF.md
# Two-Domain Module Power Sequencer

This block governs the clock enable and reset of a small set of peripheral modules that are split over two power domains. One domain is permanently powered; the other can be switched on and off. Software programs each module's desired state (disabled, held in synchronous reset, or enabled) into a per-module control word. That request stays dormant until software issues a per-domain GO command. The domain sequencer then walks the domain's modules in ascending id order. It spends a fixed, programmable number of cycles on every module whose state must change, and it flags the domain busy until the walk ends.

The switchable domain starts from power-off. A GO for that domain while power is requested first raises an external-power pending flag and waits. Software drives the power switch, marks the domain ready in its control word and clears the pending flag. Once the external power-good input is high, the modules of that domain are brought up. A GO with the power request cleared shuts the domain down and returns its modules to disabled.

Access is through a simple word bus with a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `pwrctl`

## Requirements
- R1: After reset, busy_o, clk_en_o, rst_n_o and pwr_sw_o are all zero, every module status reads 0 (disabled), and the switchable-domain status word (byte 0x018) reads 0.
- R2: A write to a module control word (byte 0x100 + 4*id) keeps bits 1:0 (next state: 0 disabled, 1 synchronous reset, 3 enabled) and bit 9 (auxiliary enable). A read returns those bits and returns zero in all others. Read data is valid one cycle after rd_en.
- R3: Writing a next state changes neither module status (byte 0x200 + 4*id, bits 1:0) nor any module output until a GO for that module's domain is written.
- R4: Writing bit 0 of the command word (byte 0x000) starts the always-on domain. busy_o[0] and bit 0 of the transition status word (byte 0x004) stay at 1 for exactly NUM_AON + k*TRANS_CYC cycles, where k is the number of modules whose status differs from their request. A module that already matches its request costs one cycle.
- R5: Modules of one domain are updated one after another in ascending id order.
- R6: A GO written while the same domain is busy is ignored and does not lengthen the busy period.
- R7: The outputs follow the module state, one cycle after the status changes. Enabled gives clk_en=1 and rst_n=1. Synchronous reset gives clk_en=1 and rst_n=0. Disabled gives 0 and 0.
- R8: Writing bit 1 of the command word while bit 0 of the domain control word (byte 0x008) is set and the switchable domain is off has three effects. It sets bit 1 of the pending word (byte 0x00C) and holds busy_o[1] at 1. The domain does not come up until all three hold: bit 1 has been written to the clear word (byte 0x010), bit 8 of the domain control word is set, and pwr_good_i is 1. The domain status word then reads 1.
- R9: While the switchable domain is off, its modules hold clk_en_o and rst_n_o at 0.
- R10: Writing bit 1 of the command word with domain control bit 0 clear powers the switchable domain off in one busy cycle and sets its module statuses to disabled.
- R11: Control or status reads of a module id at or above NUM_AON+NUM_SW return zero, and writes to such ids change no register.
- R12: Bit 0 of the power-switch word (byte 0x014) drives pwr_sw_o.
- R13: A next-state write that lands while the sequencer is still working on that module is honoured in the same pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| busy_o | output | 2 | Domain busy flags (bit 0 always-on, bit 1 switchable) |
| pwr_sw_o | output | 1 | Power switch drive |
| pwr_good_i | input | 1 | External power-good acknowledge |
| clk_en_o | output | NUM_AON+NUM_SW | Per-module clock enable |
| rst_n_o | output | NUM_AON+NUM_SW | Per-module active-low reset |

## Verification
A software write to a module's next-state field can land in the same cycle in which that module's sequencer finishes counting and commits a new status. The bench provokes this by rewriting the next state of a switchable-domain module a few cycles after GO, while the sequencer is still counting that module. It then judges the result by the status read back and the output pair: the module must end in the newest requested state, not the one that was pending when GO was written. A second GO issued in the middle of a busy period is also checked, by counting the busy cycles against the value expected from the modules that had to change.

// File: rtl/pwrctl_pkg.sv
`timescale 1ns/1ps
package pwrctl_pkg;
  // module state codes
  localparam logic [1:0] ST_OFF  = 2'd0;
  localparam logic [1:0] ST_SRST = 2'd1;
  localparam logic [1:0] ST_ON   = 2'd3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_PWR, SQ_RUN, SQ_OFF} sq_e;

  typedef struct packed {
    logic       aux;
    logic [1:0] nxt;
  } mctl_t;

  // system word indices (byte address / 4)
  localparam logic [5:0] W_CMD   = 6'd0;
  localparam logic [5:0] W_TSTAT = 6'd1;
  localparam logic [5:0] W_PDCTL = 6'd2;
  localparam logic [5:0] W_PEND  = 6'd3;
  localparam logic [5:0] W_PCLR  = 6'd4;
  localparam logic [5:0] W_PSW   = 6'd5;
  localparam logic [5:0] W_PDST  = 6'd6;
endpackage

// File: rtl/pwrctl_seq.sv
`timescale 1ns/1ps
module pwrctl_seq
  import pwrctl_pkg::*;
#(
  parameter int N         = 4,
  parameter int TRANS_CYC = 4,
  parameter int GATED     = 0,
  parameter int IW        = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          pd_req,
  input  logic          iso_rel,
  input  logic          pwr_good,
  input  logic          pend_clr,
  input  logic          match,
  output logic [IW-1:0] idx,
  output logic          upd,
  output logic          clr_all,
  output logic          busy,
  output logic          pd_on,
  output logic          pend
);
  localparam int CW = (TRANS_CYC > 1) ? $clog2(TRANS_CYC) : 1;
  localparam logic [CW-1:0] CLAST = CW'(TRANS_CYC - 1);
  localparam logic [IW-1:0] ILAST = IW'(N - 1);

  sq_e           st;
  logic [CW-1:0] cnt;
  logic          pwr_ok;

  generate
    if (GATED != 0) begin : g_gated
      always_ff @(posedge clk) begin
        if (rst) begin
          pd_on <= 1'b0;
          pend  <= 1'b0;
        end else begin
          if (pend_clr) pend <= 1'b0;
          if (st == SQ_IDLE && go && pd_req && !pd_on) pend <= 1'b1;
          if (st == SQ_PWR && pwr_ok) pd_on <= 1'b1;
          if (st == SQ_OFF) pd_on <= 1'b0;
        end
      end
      assign pwr_ok = !pend && pwr_good && iso_rel;
    end else begin : g_aon
      logic unused_aon;
      assign unused_aon = &{1'b0, iso_rel, pwr_good, pend_clr};
      assign pd_on  = 1'b1;
      assign pend   = 1'b0;
      assign pwr_ok = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SQ_IDLE;
      idx <= '0;
      cnt <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (go) begin
          idx <= '0;
          cnt <= '0;
          if (GATED != 0 && !pd_req) st <= SQ_OFF;
          else if (!pd_on)           st <= SQ_PWR;
          else                       st <= SQ_RUN;
        end
        SQ_PWR: if (pwr_ok) st <= SQ_RUN;
        SQ_RUN: begin
          if (match) begin
            cnt <= '0;
            if (idx == ILAST) st <= SQ_IDLE;
            else              idx <= idx + 1'b1;
          end else if (cnt == CLAST) begin
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign upd     = (st == SQ_RUN) && !match && (cnt == CLAST);
  assign clr_all = (st == SQ_OFF);
  assign busy    = (st != SQ_IDLE);
endmodule

// File: rtl/pwrctl_modout.sv
`timescale 1ns/1ps
module pwrctl_modout
  import pwrctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] state,
  input  logic       pwr_ok,
  output logic       clk_en,
  output logic       rst_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en <= 1'b0;
      rst_n  <= 1'b0;
    end else begin
      clk_en <= pwr_ok && (state == ST_ON || state == ST_SRST);
      rst_n  <= pwr_ok && (state == ST_ON);
    end
  end
endmodule

// File: rtl/pwrctl.sv
`timescale 1ns/1ps
module pwrctl
  import pwrctl_pkg::*;
#(
  parameter int NUM_AON   = 4,
  parameter int NUM_SW    = 2,
  parameter int TRANS_CYC = 4,
  parameter int AW        = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [AW-1:0]               addr,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  output logic [1:0]                  busy_o,
  output logic                        pwr_sw_o,
  input  logic                        pwr_good_i,
  output logic [NUM_AON+NUM_SW-1:0]   clk_en_o,
  output logic [NUM_AON+NUM_SW-1:0]   rst_n_o
);
  localparam int NUM_MOD = NUM_AON + NUM_SW;
  localparam int MAXN    = (NUM_AON > NUM_SW) ? NUM_AON : NUM_SW;
  localparam int IW      = (MAXN > 1) ? $clog2(MAXN) : 1;
  localparam int RW      = AW - 8;
  localparam logic [RW-1:0] REG_SYS = RW'(0);
  localparam logic [RW-1:0] REG_CTL = RW'(1);
  localparam logic [RW-1:0] REG_STA = RW'(2);

  // decode
  logic [RW-1:0] region;
  logic [5:0]    wsel;
  logic          id_ok, wr_sys, wr_ctl, pend_clr;
  logic [1:0]    go_vec;

  assign region   = addr[AW-1:8];
  assign wsel     = addr[7:2];
  assign id_ok    = int'(wsel) < NUM_MOD;
  assign wr_sys   = wr_en && (region == REG_SYS);
  assign wr_ctl   = wr_en && (region == REG_CTL) && id_ok;
  assign go_vec   = (wr_sys && wsel == W_CMD) ? wdata[1:0] : 2'b00;
  assign pend_clr = wr_sys && (wsel == W_PCLR) && wdata[1];

  // register state
  mctl_t      ctl  [NUM_MOD];
  logic [1:0] stat [NUM_MOD];
  logic       pd_req, iso_rel, psw;

  logic [1:0][IW-1:0] sq_idx;
  logic [1:0]         sq_upd, sq_clr, sq_busy, sq_pdon, sq_pend;
  logic               sw_pd_on, sw_pend;

  assign sw_pd_on = sq_pdon[1];
  assign sw_pend  = sq_pend[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_req  <= 1'b0;
      iso_rel <= 1'b0;
      psw     <= 1'b0;
      for (int m = 0; m < NUM_MOD; m++) ctl[m] <= '0;
    end else begin
      if (wr_sys && wsel == W_PDCTL) begin
        pd_req  <= wdata[0];
        iso_rel <= wdata[8];
      end
      if (wr_sys && wsel == W_PSW) psw <= wdata[0];
      for (int m = 0; m < NUM_MOD; m++)
        if (wr_ctl && int'(wsel) == m) ctl[m] <= '{aux: wdata[9], nxt: wdata[1:0]};
    end
  end

  // per-domain sequencers
  generate
    for (genvar d = 0; d < 2; d++) begin : g_dom
      localparam int BASE = (d == 0) ? 0 : NUM_AON;
      localparam int CNT  = (d == 0) ? NUM_AON : NUM_SW;
      logic mt;
      always_comb begin
        mt = 1'b0;
        for (int m = 0; m < CNT; m++)
          if (int'(sq_idx[d]) == m) mt = (stat[BASE+m] == ctl[BASE+m].nxt);
      end
      pwrctl_seq #(.N(CNT), .TRANS_CYC(TRANS_CYC), .GATED(d), .IW(IW)) u_seq (
        .clk(clk), .rst(rst), .go(go_vec[d]), .pd_req(pd_req), .iso_rel(iso_rel),
        .pwr_good(pwr_good_i), .pend_clr(pend_clr), .match(mt),
        .idx(sq_idx[d]), .upd(sq_upd[d]), .clr_all(sq_clr[d]), .busy(sq_busy[d]),
        .pd_on(sq_pdon[d]), .pend(sq_pend[d])
      );
    end
  endgenerate

  // status commit
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < NUM_MOD; m++) stat[m] <= ST_OFF;
    end else begin
      for (int m = 0; m < NUM_MOD; m++) begin
        if (m < NUM_AON) begin
          if (sq_upd[0] && int'(sq_idx[0]) == m) stat[m] <= ctl[m].nxt;
        end else begin
          if (sq_clr[1]) stat[m] <= ST_OFF;
          else if (sq_upd[1] && int'(sq_idx[1]) == m - NUM_AON) stat[m] <= ctl[m].nxt;
        end
      end
    end
  end

  // module outputs
  generate
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
      logic pok;
      if (m < NUM_AON) begin : g_a
        assign pok = 1'b1;
      end else begin : g_s
        assign pok = sw_pd_on;
      end
      pwrctl_modout u_out (
        .clk(clk), .rst(rst), .state(stat[m]), .pwr_ok(pok),
        .clk_en(clk_en_o[m]), .rst_n(rst_n_o[m])
      );
    end
  endgenerate

  // registered read
  logic [31:0] rd_nxt;
  always_comb begin
    rd_nxt = '0;
    if (region == REG_SYS) begin
      case (wsel)
        W_TSTAT: rd_nxt[1:0] = sq_busy;
        W_PDCTL: begin rd_nxt[0] = pd_req; rd_nxt[8] = iso_rel; end
        W_PEND:  rd_nxt[1] = sw_pend;
        W_PSW:   rd_nxt[0] = psw;
        W_PDST:  rd_nxt[4:0] = {4'd0, sw_pd_on};
        default: rd_nxt = '0;
      endcase
    end else if (region == REG_CTL) begin
      for (int m = 0; m < NUM_MOD; m++)
        if (int'(wsel) == m) begin
          rd_nxt[9]   = ctl[m].aux;
          rd_nxt[1:0] = ctl[m].nxt;
        end
    end else if (region == REG_STA) begin
      for (int m = 0; m < NUM_MOD; m++)
        if (int'(wsel) == m) rd_nxt[1:0] = stat[m];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_nxt;
  end

  assign busy_o   = sq_busy;
  assign pwr_sw_o = psw;

  logic unused_bits;
  assign unused_bits = &{1'b0, sq_pdon[0], sq_pend[0], sq_clr[0], addr[1:0],
                         wdata[31:10], wdata[7:2]};
endmodule

// File: rtl/pwrctl_chk.sv
`timescale 1ns/1ps
module pwrctl_chk #(
  parameter int NUM_AON = 4,
  parameter int NUM_SW  = 2,
  parameter int NM      = NUM_AON + NUM_SW
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    busy,
  input logic [NM-1:0] ce,
  input logic [NM-1:0] rn,
  input logic          pd_on,
  input logic          pend
);
  // R7: a released reset always comes with a running clock
  assert_rst_needs_clk_R7: assert property (@(posedge clk) disable iff (rst)
    (rn & ~ce) == '0)
    else $error("R7 rst_n released without clk_en");

  // R9: switchable modules stay inactive after the domain was off
  assert_gated_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(pd_on) |-> (ce[NM-1:NUM_AON] == '0 && rn[NM-1:NUM_AON] == '0))
    else $error("R9 gated module active while domain off");

  // R8: pending power request implies the switchable domain is busy
  assert_pend_busy_R8: assert property (@(posedge clk) disable iff (rst)
    pend |-> busy[1])
    else $error("R8 pending flag without busy");

  // R3: always-on outputs only move as a result of a transition
  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy[0] && !$past(busy[0])) |->
      ($stable(ce[NUM_AON-1:0]) && $stable(rn[NUM_AON-1:0])))
    else $error("R3 always-on outputs moved while idle");
endmodule

bind pwrctl pwrctl_chk #(.NUM_AON(NUM_AON), .NUM_SW(NUM_SW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy_o), .ce(clk_en_o), .rn(rst_n_o),
  .pd_on(sw_pd_on), .pend(sw_pend)
);

// File: tb/pwrctl_test.sv
`timescale 1ns/1ps
module pwrctl_test;
  localparam int NA = 4, NS = 2, NM = NA + NS, TC = 4, AW = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, pwr_good_i = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] busy_o;
  logic pwr_sw_o;
  logic [NM-1:0] clk_en_o, rst_n_o;

  pwrctl #(.NUM_AON(NA), .NUM_SW(NS), .TRANS_CYC(TC), .AW(AW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy_o(busy_o), .pwr_sw_o(pwr_sw_o), .pwr_good_i(pwr_good_i),
    .clk_en_o(clk_en_o), .rst_n_o(rst_n_o));

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0, errors = 0, cyc = 0;
  // reference model state
  int exp_stat [NM];
  bit exp_pdon = 0;
  bit mdl_ok = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      summary();
    end
  end

  // per-clock comparison of module outputs against the model (R7, R9)
  always @(negedge clk) begin
    if (!rst && mdl_ok) begin
      logic [NM-1:0] ece, ern;
      for (int m = 0; m < NM; m++) begin
        bit pok = (m < NA) ? 1'b1 : exp_pdon;
        ece[m] = pok && (exp_stat[m] == 3 || exp_stat[m] == 1);
        ern[m] = pok && (exp_stat[m] == 3);
      end
      chk({clk_en_o, rst_n_o} == {ece, ern}, "R7/R9 model", {clk_en_o, rst_n_o}, {ece, ern});
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic settle(input int d);
    int n = 0;
    while (busy_o[d] && n < 1000) begin n++; @(negedge clk); end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int n, t0, t1;
    for (int m = 0; m < NM; m++) exp_stat[m] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(busy_o == 0 && clk_en_o == 0 && rst_n_o == 0 && pwr_sw_o == 0, "R1 outputs",
        {busy_o, clk_en_o, rst_n_o, pwr_sw_o}, 0);
    rd(32'h018, v); chk(v == 0, "R1 domain status", v, 0);
    rd(32'h200, v); chk(v == 0, "R1 module status", v, 0);
    mdl_ok = 1;

    // R2 control word storage
    wr(32'h100, 32'hFEF3);
    rd(32'h100, v); chk(v == 32'h203, "R2 ctl readback", v, 32'h203);
    wr(32'h104, 1);
    // R3 nothing moves before GO
    repeat (6) @(negedge clk);
    rd(32'h200, v); chk(v == 0, "R3 status before go", v, 0);
    chk(clk_en_o == 0, "R3 outputs before go", clk_en_o, 0);

    // R4, R5 always-on transition, two modules change
    mdl_ok = 0;
    wr(32'h000, 1);
    n = 0; t0 = -1; t1 = -1;
    while (busy_o[0] && n < 1000) begin
      if (clk_en_o[0] && t0 < 0) t0 = n;
      if (clk_en_o[1] && t1 < 0) t1 = n;
      n++; @(negedge clk);
    end
    chk(n == NA + 2*TC, "R4 busy length", n, NA + 2*TC);
    chk(t0 >= 0 && t1 > t0, "R5 ascending order", t1, t0);
    exp_stat[0] = 3; exp_stat[1] = 1;
    repeat (2) @(negedge clk); mdl_ok = 1;

    // R4 already matching modules, transition status word
    mdl_ok = 0;
    wr(32'h000, 1);
    rd(32'h004, v); chk(v[0] == 1'b1, "R4 tstat busy bit", v, 1);
    settle(0);
    rd(32'h004, v); chk(v == 0, "R4 tstat idle", v, 0);
    mdl_ok = 1;

    // R6 GO during busy ignored
    wr(32'h108, 3);
    mdl_ok = 0;
    wr(32'h000, 1);
    n = 0;
    while (busy_o[0] && n < 1000) begin
      if (n == 3) begin wr_en = 1'b1; addr = '0; wdata = 1; end
      else wr_en = 1'b0;
      n++; @(negedge clk);
    end
    wr_en = 1'b0;
    chk(n == NA + TC, "R6 busy length", n, NA + TC);
    exp_stat[2] = 3;
    repeat (2) @(negedge clk); mdl_ok = 1;

    // R7 explicit state to output mapping
    chk(clk_en_o[0] && rst_n_o[0], "R7 enabled", {clk_en_o[0], rst_n_o[0]}, 3);
    chk(clk_en_o[1] && !rst_n_o[1], "R7 sync reset", {clk_en_o[1], rst_n_o[1]}, 2);
    chk(!clk_en_o[3] && !rst_n_o[3], "R7 disabled", {clk_en_o[3], rst_n_o[3]}, 0);

    // R12 power switch
    wr(32'h014, 1);
    chk(pwr_sw_o == 1'b1, "R12 pwr_sw_o", pwr_sw_o, 1);

    // R8, R9 power-up handshake
    wr(32'h110, 3);
    wr(32'h008, 1);
    mdl_ok = 0;
    wr(32'h000, 2);
    rd(32'h00C, v); chk(v == 2, "R8 pending set", v, 2);
    chk(busy_o[1] == 1'b1, "R8 busy while pending", busy_o, 2);
    pwr_good_i = 1'b1;
    wr(32'h010, 2);
    rd(32'h00C, v); chk(v == 0, "R8 pending cleared", v, 0);
    repeat (5) @(negedge clk);
    chk(busy_o[1] == 1'b1, "R8 waits for ready bit", busy_o, 2);
    chk(clk_en_o[NM-1:NA] == 0, "R9 gated quiet", clk_en_o, 0);
    rd(32'h018, v); chk(v == 0, "R8 domain still off", v, 0);
    wr(32'h008, 32'h101);
    settle(1);
    rd(32'h018, v); chk(v == 1, "R8 domain on", v, 1);
    exp_pdon = 1; exp_stat[4] = 3;
    mdl_ok = 1;
    chk(clk_en_o[4] && rst_n_o[4], "R8 gated module up", {clk_en_o[4], rst_n_o[4]}, 3);

    // R13 next-state rewritten during the pass
    wr(32'h114, 3);
    mdl_ok = 0;
    wr(32'h000, 2);
    repeat (2) @(negedge clk);
    wr(32'h114, 1);
    settle(1);
    rd(32'h214, v); chk(v == 1, "R13 newest request wins", v, 1);
    exp_stat[5] = 1;
    mdl_ok = 1;
    chk(clk_en_o[5] && !rst_n_o[5], "R13 outputs", {clk_en_o[5], rst_n_o[5]}, 2);

    // R10 power-down
    wr(32'h008, 0);
    mdl_ok = 0;
    wr(32'h000, 2);
    n = 0;
    while (busy_o[1] && n < 1000) begin n++; @(negedge clk); end
    chk(n == 1, "R10 busy length", n, 1);
    rd(32'h018, v); chk(v == 0, "R10 domain off", v, 0);
    rd(32'h210, v); chk(v == 0, "R10 status cleared", v, 0);
    exp_pdon = 0; exp_stat[4] = 0; exp_stat[5] = 0;
    @(negedge clk); mdl_ok = 1;
    @(negedge clk);
    chk(clk_en_o[NM-1:NA] == 0 && rst_n_o[NM-1:NA] == 0, "R10 R9 outputs off",
        {clk_en_o, rst_n_o}, 0);

    // R11 unimplemented ids
    wr(32'h128, 3);
    rd(32'h128, v); chk(v == 0, "R11 ctl read", v, 0);
    rd(32'h228, v); chk(v == 0, "R11 status read", v, 0);
    rd(32'h108, v); chk(v == 3, "R11 no alias write", v, 3);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule